// File: doc/BRIEF.md
# Rotating priority interrupt resolver

This block is the decision core of an eight-input interrupt controller. From the pending request vector, the mask vector and the in-service vector, it decides whether some unmasked pending request ranks strictly above every interrupt that is still being serviced. If one does, it reports the position of that request. The controller raises its interrupt line from the valid flag. It also uses the index when the processor acknowledges.

Rank is relative, not fixed. A rotation offset names the input that currently holds top rank, and rank falls off in ascending position order from there, wrapping past the last input. The in-service vector is ranked the same way. Three mode flags adjust which in-service bits count:

- Special mask mode removes masked bits from the in-service level.
- Nested mode, on the master unit, removes the cascade input, so a slave can interrupt while another of its requests is being serviced.

The block is purely combinational. It holds no state and has no handshake. Request latching, command decoding and vector generation sit around it.

Top module: `rpr_top`

## Requirements
- R1: Only requests that are pending and not masked take part (a bit set in `req_mask` removes that input from the request side). A masked request never produces `irq_valid`.
- R2: Request rank is taken relative to `rot_off`. Input position (p + rot_off) mod 8 has rank p, and a smaller rank wins. For example, with `rot_off`=1, input 7 outranks input 0.
- R3: With no pending unmasked request, `irq_valid` is 0.
- R4: The in-service level is the best rank, under the same rotation, among the counted `in_serv` bits. A request is reported only if its rank is strictly smaller than that level. An equal or worse rank gives `irq_valid`=0. An empty in-service set never blocks.
- R5: When `spec_mask_en`=1, in-service bits whose `req_mask` bit is set are not counted in the in-service level. When `spec_mask_en`=0, they are counted.
- R6: When `nest_en`=1 and `is_master`=1, in-service bit 2 (the cascade input) is not counted. When `is_master`=0, that bit is counted whatever `nest_en` is.
- R7: `irq_idx` is the input position of the winning request. When `irq_valid`=0, `irq_idx` is 0.
- R8: Outputs follow the inputs combinationally, with no clock and no latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_pend | input | 8 | Pending request bits, one per input |
| req_mask | input | 8 | Mask bits; 1 disables that input |
| in_serv | input | 8 | In-service bits, one per input |
| rot_off | input | 3 | Input position currently holding top rank |
| spec_mask_en | input | 1 | Special mask mode enable |
| nest_en | input | 1 | Special fully nested mode enable |
| is_master | input | 1 | 1 when this unit is the cascade master |
| irq_valid | output | 1 | A request outranks the in-service level |
| irq_idx | output | 3 | Position of the winning request, 0 when none |

## Verification
The bench builds the block with its default parameters: eight inputs, with the cascade on input 2. Every one of the eight rotation offsets is crossed with all eight combinations of the three mode flags. Each of these 64 corners receives a thousand seeded vectors, so wrap-around ranking, strict-versus-equal comparison and both exclusion rules all occur under every rotation. Directed vectors pin the named boundary cases: equal rank, a masked in-service bit, and cascade-bit exclusion on master versus slave.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  // position of rank p under rotation off, for an n-input ring
  function automatic int unsigned ring_pos(int unsigned p, int unsigned off, int unsigned n);
    return (p + off) % n;
  endfunction
endpackage

// File: rtl/rpr_scan.sv
module rpr_scan #(
  parameter int N  = 8,
  localparam int IW = $clog2(N),
  localparam int LW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] off,
  output logic [LW-1:0] lvl
);
  logic [N-1:0] rot;

  // rank-ordered view: rot[p] is the input holding rank p
  always_comb begin
    for (int p = 0; p < N; p++) begin
      rot[p] = vec[IW'(rpr_pkg::ring_pos(p, 32'(off), N))];
    end
  end

  // best (smallest) rank present; N when empty
  always_comb begin
    lvl = LW'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot[p]) lvl = LW'(p);
    end
  end
endmodule

// File: rtl/rpr_isr_filter.sv
module rpr_isr_filter #(
  parameter int N   = 8,
  parameter int CAS = 2
) (
  input  logic [N-1:0] in_serv,
  input  logic [N-1:0] req_mask,
  input  logic         spec_mask_en,
  input  logic         nest_en,
  input  logic         is_master,
  output logic [N-1:0] counted
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      if (g == CAS) begin : g_cas
        assign counted[g] = in_serv[g] & ~(spec_mask_en & req_mask[g])
                            & ~(nest_en & is_master);
      end else begin : g_norm
        assign counted[g] = in_serv[g] & ~(spec_mask_en & req_mask[g]);
      end
    end
  endgenerate
endmodule

// File: rtl/rpr_top.sv
module rpr_top #(
  parameter int N   = 8,
  parameter int CAS = 2,
  localparam int IW = $clog2(N),
  localparam int LW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_pend,
  input  logic [N-1:0]  req_mask,
  input  logic [N-1:0]  in_serv,
  input  logic [IW-1:0] rot_off,
  input  logic          spec_mask_en,
  input  logic          nest_en,
  input  logic          is_master,
  output logic          irq_valid,
  output logic [IW-1:0] irq_idx
);
  logic [N-1:0]  cand;
  logic [N-1:0]  srv_cnt;
  logic [LW-1:0] req_lvl;
  logic [LW-1:0] srv_lvl;

  assign cand = req_pend & ~req_mask;

  rpr_isr_filter #(.N(N), .CAS(CAS)) u_filt (
    .in_serv      (in_serv),
    .req_mask     (req_mask),
    .spec_mask_en (spec_mask_en),
    .nest_en      (nest_en),
    .is_master    (is_master),
    .counted      (srv_cnt)
  );

  rpr_scan #(.N(N)) u_req_scan (.vec(cand),    .off(rot_off), .lvl(req_lvl));
  rpr_scan #(.N(N)) u_srv_scan (.vec(srv_cnt), .off(rot_off), .lvl(srv_lvl));

  // empty request side yields N, which can never be below srv_lvl
  assign irq_valid = req_lvl < srv_lvl;
  assign irq_idx   = irq_valid
                     ? IW'(rpr_pkg::ring_pos(32'(req_lvl), 32'(rot_off), N))
                     : '0;
endmodule

// File: rtl/rpr_chk.sv
module rpr_chk #(
  parameter int N   = 8,
  parameter int CAS = 2,
  localparam int IW = $clog2(N)
) (
  input logic [N-1:0]  req_pend,
  input logic [N-1:0]  req_mask,
  input logic [N-1:0]  in_serv,
  input logic [IW-1:0] rot_off,
  input logic          spec_mask_en,
  input logic          nest_en,
  input logic          is_master,
  input logic          irq_valid,
  input logic [IW-1:0] irq_idx
);
  logic [N-1:0] cnd;
  assign cnd = req_pend & ~req_mask;

  always_comb begin
    // R1: the winner is a pending, unmasked input
    a_r1_winner_unmasked: assert (!irq_valid || cnd[irq_idx]);
    // R3: no candidate, no request
    a_r3_idle_no_valid: assert (cnd != '0 || !irq_valid);
    // R7: index parked at zero when idle
    a_r7_idle_idx_zero: assert (irq_valid || irq_idx == '0);
    // R4: nothing in service never blocks a candidate
    a_r4_empty_srv_passes: assert (in_serv != '0 || cnd == '0 || irq_valid);
    // R4/R6: a counted in-service bit at the winner would tie, so it must be clear
    a_r4_no_tie_win: assert (!irq_valid || !in_serv[irq_idx]
                             || (nest_en && is_master && 32'(irq_idx) == CAS));
    // R2: rank relative to rot_off; the top-rank input wins whenever it is a candidate and nothing is in service
    a_r2_top_rank_wins: assert (!(cnd[rot_off] && in_serv == '0) || irq_idx == rot_off);
  end
endmodule

bind rpr_top rpr_chk #(.N(N), .CAS(CAS)) u_chk (
  .req_pend     (req_pend),
  .req_mask     (req_mask),
  .in_serv      (in_serv),
  .rot_off      (rot_off),
  .spec_mask_en (spec_mask_en),
  .nest_en      (nest_en),
  .is_master    (is_master),
  .irq_valid    (irq_valid),
  .irq_idx      (irq_idx)
);

// File: tb/sim_rpr_top.sv
module sim_rpr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [7:0] req_pend, req_mask, in_serv;
  logic [2:0] rot_off;
  logic spec_mask_en, nest_en, is_master;
  logic irq_valid;
  logic [2:0] irq_idx;

  int errors = 0;
  int checks = 0;

  rpr_top u0 (
    .req_pend(req_pend), .req_mask(req_mask), .in_serv(in_serv),
    .rot_off(rot_off), .spec_mask_en(spec_mask_en), .nest_en(nest_en),
    .is_master(is_master), .irq_valid(irq_valid), .irq_idx(irq_idx)
  );

  // independent arithmetic model: walk ranks from the offset
  task automatic model(input logic [7:0] p, m, s, input logic [2:0] o,
                       input logic sm, ne, ms, output logic v, output logic [2:0] ix);
    int rq, sv;
    logic [7:0] c, k;
    c = p & ~m;
    k = s;
    if (sm) k = k & ~m;
    if (ne && ms) k[2] = 1'b0;
    rq = 8; sv = 8;
    for (int r = 7; r >= 0; r--) begin
      if (c[(r + o) % 8]) rq = r;
      if (k[(r + o) % 8]) sv = r;
    end
    v  = (rq < sv);
    ix = v ? 3'((rq + o) % 8) : 3'd0;
  endtask

  task automatic drive(input logic [7:0] p, m, s, input logic [2:0] o,
                       input logic sm, ne, ms);
    req_pend = p; req_mask = m; in_serv = s; rot_off = o;
    spec_mask_en = sm; nest_en = ne; is_master = ms;
  endtask

  task automatic expect_out(input logic ev, input logic [2:0] ei, input string tag);
    checks++;
    if (irq_valid !== ev || irq_idx !== ei) begin
      errors++;
      $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
               tag, irq_valid, irq_idx, ev, ei);
    end
  endtask

  task automatic dir(input logic [7:0] p, m, s, input logic [2:0] o,
                     input logic sm, ne, ms, input logic ev, input logic [2:0] ei,
                     input string tag);
    @(posedge clk);
    drive(p, m, s, o, sm, ne, ms);
    #5;
    expect_out(ev, ei, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic ev;
    logic [2:0] ei;
    drive(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #5;
    expect_out(1'b0, 3'd0, "R3 R7 reset idle");
    rst_n = 1'b1;

    dir(8'h01, 8'h01, 8'h00, 3'd0, 0, 0, 0, 1'b0, 3'd0, "R1 masked only");
    dir(8'h03, 8'h01, 8'h00, 3'd0, 0, 0, 0, 1'b1, 3'd1, "R1 unmasked next");
    dir(8'h81, 8'h00, 8'h00, 3'd0, 0, 0, 0, 1'b1, 3'd0, "R2 offset 0");
    dir(8'h81, 8'h00, 8'h00, 3'd1, 0, 0, 0, 1'b1, 3'd7, "R2 offset 1 wrap");
    dir(8'h21, 8'h00, 8'h00, 3'd6, 0, 0, 0, 1'b1, 3'd0, "R2 offset 6");
    dir(8'h00, 8'hFF, 8'hFF, 3'd3, 1, 1, 1, 1'b0, 3'd0, "R3 no pending");
    dir(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, 0, 1'b0, 3'd0, "R4 equal rank");
    dir(8'h04, 8'h00, 8'h08, 3'd0, 0, 0, 0, 1'b1, 3'd2, "R4 higher rank");
    dir(8'h10, 8'h00, 8'h08, 3'd0, 0, 0, 0, 1'b0, 3'd0, "R4 lower rank");
    dir(8'h08, 8'h00, 8'h10, 3'd4, 0, 0, 0, 1'b0, 3'd0, "R4 rotated lower");
    dir(8'h10, 8'h08, 8'h08, 3'd0, 1, 0, 0, 1'b1, 3'd4, "R5 masked srv ignored");
    dir(8'h10, 8'h08, 8'h08, 3'd0, 0, 0, 0, 1'b0, 3'd0, "R5 off srv counts");
    dir(8'h10, 8'h00, 8'h04, 3'd0, 0, 1, 1, 1'b1, 3'd4, "R6 master cascade ignored");
    dir(8'h10, 8'h00, 8'h04, 3'd0, 0, 1, 0, 1'b0, 3'd0, "R6 slave cascade counts");
    dir(8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 1, 1'b1, 3'd2, "R6 cascade re-entry");
    dir(8'h04, 8'h00, 8'h04, 3'd0, 0, 0, 1, 1'b0, 3'd0, "R6 nest off");
    dir(8'h40, 8'h00, 8'h00, 3'd2, 0, 0, 0, 1'b1, 3'd6, "R7 index");

    // R8: change inputs between edges; outputs settle without a clock
    @(negedge clk);
    drive(8'h20, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    #1;
    expect_out(1'b1, 3'd5, "R8 no latency a");
    drive(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    #1;
    expect_out(1'b0, 3'd0, "R8 no latency b");

    // sweep: every offset and mode combination, seeded vectors
    void'($urandom(32'h5eed));
    for (int o = 0; o < 8; o++) begin
      for (int md = 0; md < 8; md++) begin
        for (int n = 0; n < 1000; n++) begin
          logic [7:0] p, m, s;
          p = 8'($urandom);
          m = 8'($urandom) & 8'($urandom);
          s = 8'($urandom) & 8'($urandom);
          @(posedge clk);
          drive(p, m, s, 3'(o), md[0], md[1], md[2]);
          model(p, m, s, 3'(o), md[0], md[1], md[2], ev, ei);
          #5;
          expect_out(ev, ei, "R2 R4 R5 R6 R7 sweep");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule